// File: doc/BRIEF.md
# Pipeline Interlock and Forwarding Unit

This block is the hazard controller for an in-order pipeline with four stages: instruction fetch, operand fetch with address computation, ALU or memory access, and result store. The fetch stage hands it the decoded register fields of each fetched instruction. The block records these fields as the instruction moves through the three later stages. Each cycle it compares the source registers that the operand-fetch instruction reads with the destinations of the older instructions in the ALU/memory and result-store stages.

On a dependency the block does one of two things. It stalls operand fetch, which holds the fetch stage and sends a bubble into ALU/memory. Or, when forwarding is enabled, it tells the operand multiplexers to take the value from the result register between the ALU/memory and result-store stages instead of from the register file. Branches resolve in result store. When the datapath raises a redirect there, the block squashes the three younger wrong-path slots in a single cycle. A parameter selects between the forwarding policy and the pure-interlock policy.

Top module: `pipe_hazard_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, every stage is empty. `stall_o`, `flush_o`, `issue_o`, `fwd_o` and `rf_we_o` are all 0.
- R2: An instruction presented with `fe_valid_i` high in cycle t, and not stalled or squashed, is in operand fetch at t+1, in ALU/memory at t+2 and in result store at t+3. In result store, `rf_we_o` equals its write flag and `rf_waddr_o` equals its destination.
- R3: With FORWARD=0, operand fetch stalls while any older valid instruction in ALU/memory or in result store writes a register it reads. A producer followed directly by its consumer therefore costs two stall cycles, and `fwd_o` stays 0.
- R4: With FORWARD=1, operand fetch stalls only while the producer is in ALU/memory. When the producer is in result store, the instruction issues without stalling and the matching `fwd_o` bit is 1. Bit i selects operand i. An adjacent producer and consumer costs one stall cycle.
- R5: When the instructions in both later stages write the register an operand reads, the younger one in ALU/memory governs. The unit stalls and does not forward the older value.
- R6: Source register number 0 never causes a stall or a forward.
- R7: An operand whose use flag is 0 never causes a stall or a forward. An older instruction that is not valid, or whose write flag is 0, is never treated as a producer.
- R8: While `stall_o` is 1, the operand-fetch instruction is kept and `fe_*` is not taken. In the next cycle `alu_valid_o` is 0, and the ALU/memory instruction still moves on to result store. `issue_o` is 1 exactly when operand fetch holds a valid instruction that neither stalls nor is squashed.
- R9: `redirect_i` while result store holds a valid instruction raises `flush_o` and forces `stall_o` to 0 in that cycle. The fetched, operand-fetch and ALU/memory instructions are discarded, so the next cycle finds all three later stages empty.
- R10: `redirect_i` while result store is empty has no effect. `flush_o` stays 0 and the instructions already in flight still reach result store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fe_valid_i | input | 1 | Fetch output holds a real instruction |
| fe_wr_i | input | 1 | Fetched instruction writes a register |
| fe_dst_i | input | REG_W | Destination register of the fetched instruction |
| fe_src_i | input | NUM_SRC*REG_W | Source register numbers; operand i occupies bits [i*REG_W +: REG_W] |
| fe_use_i | input | NUM_SRC | Bit i set when operand i is actually read |
| redirect_i | input | 1 | Taken branch resolved in result store |
| stall_o | output | 1 | Hold fetch and operand fetch, bubble into ALU/memory |
| flush_o | output | 1 | Squash the younger wrong-path slots |
| issue_o | output | 1 | Operand-fetch instruction advances this cycle |
| fwd_o | output | NUM_SRC | Bit i: operand i takes the result-store register value |
| of_valid_o | output | 1 | Operand-fetch stage occupied |
| alu_valid_o | output | 1 | ALU/memory stage occupied |
| rs_valid_o | output | 1 | Result-store stage occupied |
| rf_we_o | output | 1 | Register-file write in result store |
| rf_waddr_o | output | REG_W | Register-file write address |

## Verification
The bench covers these cases:
- An adjacent load and store pair, run under both policies. A design that forwards too early, or that forgets one of the two later stages, shows the wrong number of stall cycles.
- A register written by both older instructions. A design that picks the older producer issues with no stall and a forward bit that should be 0.
- Register 0, unused operands, and producers that are invalid or do not write. A design that does not filter these stalls where it should not.
- A redirect that lands on a pending stall. A design that lets the stall win, or that flushes only two slots, leaves a wrong-path instruction alive.
- A redirect that arrives while result store is empty. A design that does not gate it kills the instructions in flight.

// File: rtl/hz_pkg.sv
package hz_pkg;

    // What the stage records do this cycle
    typedef enum logic [1:0] {
        ACT_ADVANCE = 2'd0,
        ACT_HOLD    = 2'd1,
        ACT_SQUASH  = 2'd2
    } step_e;

    // Where an operand is taken from
    typedef enum logic {
        OPND_REGFILE = 1'b0,
        OPND_FORWARD = 1'b1
    } opnd_src_e;

endpackage

// File: rtl/hz_dest_match.sv
module hz_dest_match #(
    parameter int REG_W = 4
) (
    input  logic             valid_i,
    input  logic             wr_i,
    input  logic [REG_W-1:0] dst_i,
    input  logic [REG_W-1:0] src_i,
    output logic             hit_o
);
    // A stage counts as a producer only when it is occupied and writes
    always_comb begin
        hit_o = valid_i && wr_i && (dst_i == src_i);
    end
endmodule

// File: rtl/hz_operand_check.sv
module hz_operand_check
    import hz_pkg::*;
#(
    parameter int REG_W   = 4,
    parameter bit FORWARD = 1'b1
) (
    input  logic             active_i,
    input  logic [REG_W-1:0] src_i,
    input  logic             alu_valid_i,
    input  logic             alu_wr_i,
    input  logic [REG_W-1:0] alu_dst_i,
    input  logic             rs_valid_i,
    input  logic             rs_wr_i,
    input  logic [REG_W-1:0] rs_dst_i,
    output logic             wait_o,
    output opnd_src_e        sel_o
);
    logic live;
    logic hit_alu;
    logic hit_rs;

    always_comb begin
        live = active_i && (src_i != '0);
    end

    hz_dest_match #(.REG_W(REG_W)) u_alu_match (
        .valid_i (alu_valid_i),
        .wr_i    (alu_wr_i),
        .dst_i   (alu_dst_i),
        .src_i   (src_i),
        .hit_o   (hit_alu)
    );

    hz_dest_match #(.REG_W(REG_W)) u_rs_match (
        .valid_i (rs_valid_i),
        .wr_i    (rs_wr_i),
        .dst_i   (rs_dst_i),
        .src_i   (src_i),
        .hit_o   (hit_rs)
    );

    generate
        if (FORWARD) begin : g_fwd
            // The younger producer in ALU/memory has no value yet: wait for it.
            // The older one in result store already sits in its result register.
            always_comb begin
                wait_o = live && hit_alu;
                sel_o  = (live && !hit_alu && hit_rs) ? OPND_FORWARD : OPND_REGFILE;
            end
        end else begin : g_interlock
            // Pure interlock: wait until the write has left result store
            always_comb begin
                wait_o = live && (hit_alu || hit_rs);
                sel_o  = OPND_REGFILE;
            end
        end
    endgenerate
endmodule

// File: rtl/hz_step_ctrl.sv
module hz_step_ctrl
    import hz_pkg::*;
(
    input  logic  of_valid_i,
    input  logic  any_wait_i,
    input  logic  redirect_i,
    input  logic  rs_valid_i,
    output logic  stall_o,
    output logic  flush_o,
    output logic  issue_o,
    output step_e step_o
);
    always_comb begin
        // A redirect only counts when a real instruction is resolving
        flush_o = redirect_i && rs_valid_i;
        stall_o = of_valid_i && any_wait_i && !flush_o;
        issue_o = of_valid_i && !stall_o && !flush_o;
        if (flush_o) begin
            step_o = ACT_SQUASH;
        end else if (stall_o) begin
            step_o = ACT_HOLD;
        end else begin
            step_o = ACT_ADVANCE;
        end
    end
endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
    import hz_pkg::*;
#(
    parameter int REG_W   = 4,
    parameter int NUM_SRC = 2,
    parameter bit FORWARD = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fe_valid_i,
    input  logic                     fe_wr_i,
    input  logic [REG_W-1:0]         fe_dst_i,
    input  logic [NUM_SRC*REG_W-1:0] fe_src_i,
    input  logic [NUM_SRC-1:0]       fe_use_i,
    input  logic                     redirect_i,
    output logic                     stall_o,
    output logic                     flush_o,
    output logic                     issue_o,
    output logic [NUM_SRC-1:0]       fwd_o,
    output logic                     of_valid_o,
    output logic                     alu_valid_o,
    output logic                     rs_valid_o,
    output logic                     rf_we_o,
    output logic [REG_W-1:0]         rf_waddr_o
);
    localparam int SRC_BITS = NUM_SRC * REG_W;

    typedef struct packed {
        logic                valid;
        logic                wr;
        logic [REG_W-1:0]    dst;
        logic [SRC_BITS-1:0] src;
        logic [NUM_SRC-1:0]  use_m;
    } stage_t;

    typedef struct packed {
        stage_t ofs;
        stage_t alu;
        stage_t rs;
    } pipe_t;

    pipe_t              pipe_d;
    pipe_t              pipe_q;
    stage_t             fetch_rec;
    logic [NUM_SRC-1:0] wait_w;
    opnd_src_e          sel_w [NUM_SRC];
    logic               any_wait;
    logic               stall_w;
    logic               flush_w;
    logic               issue_w;
    step_e              step_w;

    always_comb begin
        fetch_rec.valid = fe_valid_i;
        fetch_rec.wr    = fe_wr_i;
        fetch_rec.dst   = fe_dst_i;
        fetch_rec.src   = fe_src_i;
        fetch_rec.use_m = fe_use_i;
    end

    // One comparator per source operand
    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_opnd
            hz_operand_check #(
                .REG_W   (REG_W),
                .FORWARD (FORWARD)
            ) u_chk (
                .active_i    (pipe_q.ofs.valid && pipe_q.ofs.use_m[g]),
                .src_i       (pipe_q.ofs.src[g*REG_W +: REG_W]),
                .alu_valid_i (pipe_q.alu.valid),
                .alu_wr_i    (pipe_q.alu.wr),
                .alu_dst_i   (pipe_q.alu.dst),
                .rs_valid_i  (pipe_q.rs.valid),
                .rs_wr_i     (pipe_q.rs.wr),
                .rs_dst_i    (pipe_q.rs.dst),
                .wait_o      (wait_w[g]),
                .sel_o       (sel_w[g])
            );

            always_comb begin
                fwd_o[g] = issue_w && (sel_w[g] == OPND_FORWARD);
            end

            AST_ZERO_NEVER_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
                (pipe_q.ofs.src[g*REG_W +: REG_W] == '0) |-> !wait_w[g] && !fwd_o[g]) // R6
                else $error("register 0 caused a hazard");
            AST_UNUSED_NEVER_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
                !pipe_q.ofs.use_m[g] |-> !wait_w[g] && !fwd_o[g]) // R7
                else $error("unused operand caused a hazard");
            AST_FWD_NOT_OLDER: assert property (@(posedge clk) disable iff (!rst_n)
                fwd_o[g] |-> !(alu_valid_o && pipe_q.alu.wr
                               && pipe_q.alu.dst == pipe_q.ofs.src[g*REG_W +: REG_W])) // R5
                else $error("forwarded older producer over younger");
        end
    endgenerate

    always_comb begin
        any_wait = |wait_w;
    end

    hz_step_ctrl u_step (
        .of_valid_i (pipe_q.ofs.valid),
        .any_wait_i (any_wait),
        .redirect_i (redirect_i),
        .rs_valid_i (pipe_q.rs.valid),
        .stall_o    (stall_w),
        .flush_o    (flush_w),
        .issue_o    (issue_w),
        .step_o     (step_w)
    );

    // Next-state of the stage records
    always_comb begin
        pipe_d = pipe_q;
        unique case (step_w)
            ACT_SQUASH: begin
                pipe_d.ofs.valid = 1'b0;
                pipe_d.alu.valid = 1'b0;
                pipe_d.rs.valid  = 1'b0;
            end
            ACT_HOLD: begin
                pipe_d.rs  = pipe_q.alu;
                pipe_d.alu = '0;
            end
            default: begin
                pipe_d.rs  = pipe_q.alu;
                pipe_d.alu = pipe_q.ofs;
                pipe_d.ofs = fetch_rec;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    always_comb begin
        stall_o     = stall_w;
        flush_o     = flush_w;
        issue_o     = issue_w;
        of_valid_o  = pipe_q.ofs.valid;
        alu_valid_o = pipe_q.alu.valid;
        rs_valid_o  = pipe_q.rs.valid;
        rf_we_o     = pipe_q.rs.valid && pipe_q.rs.wr;
        rf_waddr_o  = pipe_q.rs.dst;
    end

    AST_FLUSH_BEATS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> !stall_o) // R9
        else $error("stall raised during flush");
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> !of_valid_o && !alu_valid_o && !rs_valid_o) // R9
        else $error("wrong-path instruction survived flush");
    AST_FLUSH_NEEDS_RS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> rs_valid_o) // R10
        else $error("flush with empty result store");
    AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> !alu_valid_o) // R8
        else $error("no bubble after stall");
    AST_STALL_KEEPS_OF: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> of_valid_o) // R8
        else $error("stalled instruction lost");
    AST_ISSUE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        issue_o |-> of_valid_o && !stall_o && !flush_o) // R8
        else $error("issue while blocked");
    AST_FWD_FROM_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        (|fwd_o) |-> rf_we_o && issue_o) // R4
        else $error("forward without a result-store writer");

endmodule

// File: tb/test_pipe_hazard_unit.sv
module test_pipe_hazard_unit;

    typedef struct packed {
        logic       v;
        logic       wr;
        logic       br;
        logic [3:0] dst;
        logic [3:0] sa;
        logic       ua;
        logic [3:0] sb;
        logic       ub;
    } ins_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    // Index 0: forwarding unit, index 1: pure interlock unit
    logic [1:0] fe_v, fe_wr, red;
    logic [3:0] fe_dst [2];
    logic [7:0] fe_src [2];
    logic [1:0] fe_use [2];
    logic [1:0] stall_w, flush_w, issue_w, ofv_w, aluv_w, rsv_w, we_w;
    logic [1:0] fwd_w [2];
    logic [3:0] wa_w [2];

    pipe_hazard_unit #(.REG_W(4), .NUM_SRC(2), .FORWARD(1'b1)) i_pipe_hazard_unit (
        .clk(clk), .rst_n(rst_n), .fe_valid_i(fe_v[0]), .fe_wr_i(fe_wr[0]),
        .fe_dst_i(fe_dst[0]), .fe_src_i(fe_src[0]), .fe_use_i(fe_use[0]),
        .redirect_i(red[0]), .stall_o(stall_w[0]), .flush_o(flush_w[0]),
        .issue_o(issue_w[0]), .fwd_o(fwd_w[0]), .of_valid_o(ofv_w[0]),
        .alu_valid_o(aluv_w[0]), .rs_valid_o(rsv_w[0]), .rf_we_o(we_w[0]),
        .rf_waddr_o(wa_w[0]));

    pipe_hazard_unit #(.REG_W(4), .NUM_SRC(2), .FORWARD(1'b0)) i_pipe_hazard_unit_nf (
        .clk(clk), .rst_n(rst_n), .fe_valid_i(fe_v[1]), .fe_wr_i(fe_wr[1]),
        .fe_dst_i(fe_dst[1]), .fe_src_i(fe_src[1]), .fe_use_i(fe_use[1]),
        .redirect_i(red[1]), .stall_o(stall_w[1]), .flush_o(flush_w[1]),
        .issue_o(issue_w[1]), .fwd_o(fwd_w[1]), .of_valid_o(ofv_w[1]),
        .alu_valid_o(aluv_w[1]), .rs_valid_o(rsv_w[1]), .rf_we_o(we_w[1]),
        .rf_waddr_o(wa_w[1]));

    int   nchk = 0;
    int   nerr = 0;
    ins_t prog [256];
    int   pc [2];
    ins_t mof [2];
    ins_t malu [2];
    ins_t mrs [2];
    int   stall_cnt [2];
    int   fwd_cnt [2];
    int   flush_cnt [2];
    int   we_cnt [2];
    int   first_we [2];
    int   cyc;
    int   force_until;
    logic rand_red;

    task automatic check(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic ins_t mk(input logic v, input logic wr, input logic [3:0] dst,
                                input logic [3:0] sa, input logic ua,
                                input logic [3:0] sb, input logic ub, input logic br);
        ins_t r;
        r.v = v; r.wr = wr; r.br = br; r.dst = dst;
        r.sa = sa; r.ua = ua; r.sb = sb; r.ub = ub;
        return r;
    endfunction

    function automatic logic writes(input ins_t p, input logic [3:0] r);
        return p.v && p.wr && (p.dst == r);
    endfunction

    task automatic clear_prog();
        for (int i = 0; i < 256; i++) prog[i] = '0;
    endtask

    task automatic step();
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            ins_t f = prog[pc[k]];
            fe_v[k]   = f.v;
            fe_wr[k]  = f.wr;
            fe_dst[k] = f.dst;
            fe_src[k] = {f.sb, f.sa};
            fe_use[k] = {f.ub, f.ua};
            red[k]    = (mrs[k].v && mrs[k].br) || (cyc < force_until)
                        || (rand_red && ($urandom % 16 == 0));
        end
        #1;
        for (int k = 0; k < 2; k++) begin
            logic [1:0] am, rm, w, fw;
            logic fl, st, iss;
            fl = red[k] && mrs[k].v;
            for (int i = 0; i < 2; i++) begin
                logic [3:0] s = (i == 1) ? mof[k].sb : mof[k].sa;
                logic u = (i == 1) ? mof[k].ub : mof[k].ua;
                logic act = mof[k].v && u && (s != 4'd0);
                am[i] = act && writes(malu[k], s);
                rm[i] = act && writes(mrs[k], s);
                w[i]  = am[i] || (rm[i] && (k == 1));
            end
            st  = !fl && (|w);
            iss = mof[k].v && !st && !fl;
            for (int i = 0; i < 2; i++) fw[i] = iss && !am[i] && rm[i] && (k == 0);
            check((k == 0) ? "R4 stall" : "R3 stall", int'(stall_w[k]), int'(st));
            check((k == 0) ? "R4 forward" : "R3 forward", int'(fwd_w[k]), int'(fw));
            check("R9 flush", int'(flush_w[k]), int'(fl));
            check("R8 issue", int'(issue_w[k]), int'(iss));
            check("R8 of_valid", int'(ofv_w[k]), int'(mof[k].v));
            check("R8 alu_valid", int'(aluv_w[k]), int'(malu[k].v));
            check("R2 rs_valid", int'(rsv_w[k]), int'(mrs[k].v));
            check("R2 rf_we", int'(we_w[k]), int'(mrs[k].v && mrs[k].wr));
            if (mrs[k].v && mrs[k].wr) check("R2 rf_waddr", int'(wa_w[k]), int'(mrs[k].dst));
            stall_cnt[k] += int'(stall_w[k]);
            fwd_cnt[k]   += int'(|fwd_w[k]);
            flush_cnt[k] += int'(flush_w[k]);
            we_cnt[k]    += int'(we_w[k]);
            if (we_w[k] && first_we[k] < 0) first_we[k] = cyc;
            if (fl) begin
                mof[k] = '0; malu[k] = '0; mrs[k] = '0;
            end else if (st) begin
                mrs[k] = malu[k]; malu[k] = '0;
            end else begin
                mrs[k] = malu[k]; malu[k] = mof[k]; mof[k] = prog[pc[k]];
            end
            if (!st) pc[k] = (pc[k] + 1) % 256;
        end
        cyc++;
    endtask

    task automatic run_prog(input int n);
        for (int k = 0; k < 2; k++) begin
            pc[k] = 0; stall_cnt[k] = 0; fwd_cnt[k] = 0;
            flush_cnt[k] = 0; we_cnt[k] = 0; first_we[k] = -1;
        end
        cyc = 0;
        for (int i = 0; i < n; i++) step();
        force_until = 0;
    endtask

    initial begin
        #2000000;
        nerr++;
        $display("FAIL watchdog: run did not end");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        clear_prog();
        force_until = 0;
        rand_red = 1'b0;
        cyc = 0;
        for (int k = 0; k < 2; k++) begin
            pc[k] = 0; mof[k] = '0; malu[k] = '0; mrs[k] = '0;
            fe_v[k] = 1'b0; fe_wr[k] = 1'b0; red[k] = 1'b1;
            fe_dst[k] = 4'd0; fe_src[k] = 8'd0; fe_use[k] = 2'd0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            // R1: everything quiet under reset, even with redirect high
            check("R1 stall", int'(stall_w[k]), 0);
            check("R1 flush", int'(flush_w[k]), 0);
            check("R1 issue", int'(issue_w[k]), 0);
            check("R1 forward", int'(fwd_w[k]), 0);
            check("R1 occupancy", int'({ofv_w[k], aluv_w[k], rsv_w[k]}), 0);
            check("R1 rf_we", int'(we_w[k]), 0);
        end
        red = 2'b00;
        rst_n = 1'b1;

        // R3 R4: producer then directly dependent store
        clear_prog();
        prog[0] = mk(1, 1, 4'd3, 4'd2, 1, 4'd0, 0, 0);
        prog[1] = mk(1, 0, 4'd0, 4'd3, 1, 4'd2, 1, 0);
        run_prog(10);
        check("R4 adjacent stalls", stall_cnt[0], 1);
        check("R4 adjacent forwards", fwd_cnt[0], 1);
        check("R3 adjacent stalls", stall_cnt[1], 2);
        check("R3 no forwards", fwd_cnt[1], 0);

        // R5: two producers of the same register
        clear_prog();
        prog[0] = mk(1, 1, 4'd5, 4'd0, 0, 4'd0, 0, 0);
        prog[1] = mk(1, 1, 4'd5, 4'd0, 0, 4'd0, 0, 0);
        prog[2] = mk(1, 0, 4'd0, 4'd1, 0, 4'd5, 1, 0);
        run_prog(10);
        check("R5 youngest stalls fwd", stall_cnt[0], 1);
        check("R5 youngest forwards", fwd_cnt[0], 1);
        check("R5 youngest stalls interlock", stall_cnt[1], 2);

        // R6: register 0 as destination and source
        clear_prog();
        prog[0] = mk(1, 1, 4'd0, 4'd0, 0, 4'd0, 0, 0);
        prog[1] = mk(1, 1, 4'd1, 4'd0, 1, 4'd0, 1, 0);
        run_prog(8);
        check("R6 stalls fwd", stall_cnt[0], 0);
        check("R6 forwards fwd", fwd_cnt[0], 0);
        check("R6 stalls interlock", stall_cnt[1], 0);

        // R7: unused operands, non-writing and invalid producers
        clear_prog();
        prog[0] = mk(1, 1, 4'd7, 4'd0, 0, 4'd0, 0, 0);
        prog[1] = mk(1, 0, 4'd0, 4'd7, 0, 4'd7, 0, 0);
        prog[2] = mk(1, 0, 4'd9, 4'd0, 0, 4'd0, 0, 0);
        prog[3] = mk(1, 0, 4'd0, 4'd9, 1, 4'd0, 0, 0);
        prog[4] = mk(0, 1, 4'd10, 4'd0, 0, 4'd0, 0, 0);
        prog[5] = mk(1, 0, 4'd0, 4'd10, 1, 4'd10, 1, 0);
        run_prog(12);
        check("R7 stalls fwd", stall_cnt[0], 0);
        check("R7 forwards fwd", fwd_cnt[0], 0);
        check("R7 stalls interlock", stall_cnt[1], 0);

        // R9: redirect lands on a pending stall
        clear_prog();
        prog[0] = mk(1, 1, 4'd4, 4'd0, 0, 4'd0, 0, 1);
        prog[1] = mk(1, 1, 4'd8, 4'd4, 1, 4'd0, 0, 0);
        run_prog(10);
        for (int k = 0; k < 2; k++) begin
            check("R9 flushes", flush_cnt[k], 1);
            check("R9 stalls", stall_cnt[k], 1);
            check("R9 writes", we_cnt[k], 1);
        end

        // R10 R2: redirect with empty result store, then latency
        clear_prog();
        prog[0] = mk(1, 1, 4'd9, 4'd0, 0, 4'd0, 0, 0);
        force_until = 3;
        run_prog(8);
        for (int k = 0; k < 2; k++) begin
            check("R10 no flush", flush_cnt[k], 0);
            check("R10 writer survives", we_cnt[k], 1);
            check("R2 write cycle", first_we[k], 3);
        end

        // Random programs with dense register reuse and stray redirects
        for (int i = 0; i < 256; i++) begin
            prog[i] = mk(($urandom % 8) != 0, $urandom % 2, 4'($urandom % 4),
                         4'($urandom % 4), $urandom % 2, 4'($urandom % 4),
                         $urandom % 2, ($urandom % 10) == 0);
        end
        rand_red = 1'b1;
        run_prog(4000);
        rand_red = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule